// File: doc/BRIEF.md
# Bidirectional Handshaked Bus Port

This block is the first group of a programmable parallel interface operating in its bidirectional mode. One 8-bit peripheral bus carries data in both directions. Incoming bytes and outgoing bytes each have their own holding latch. Five peripheral-side lines control the traffic:

- a strobe that captures the bus into the input latch;
- an input-full flag;
- an active-low output-full flag;
- an acknowledge that turns the bus drivers on;
- one shared interrupt request.

The tri-state bus is modelled as a separate data output and a drive-enable output, so that the pad logic can sit outside the block.

A host reaches the block through a small synchronous register interface:

- It reads the input latch and writes the output latch at the data address.
- At the control address it sets the two interrupt enables and three general-purpose outputs, and reads back a status byte.
- A third address holds a plain 8-bit register. This register stands in for the other group of the interface.

The peripheral inputs `stb_n` and `ack_n` are treated as already synchronised to `clk`.

Top module: `bidir_hs_port`

## Requirements
- R1: After reset, `ibf` is 0, `obf_n` is 1, `pa_oe` is 0, `intr` is 0, `gp_out` is 0, `aux_out` is 0, and a read of address 0 returns 0.
- R2: In any cycle where `stb_n` is low, `pa_in` is captured into the input latch and `ibf` is 1 from the next cycle. Address 0 (`host_addr`=0) reads the input latch on `host_rdata`.
- R3: A host read of address 0 (`host_rd`=1) clears `ibf` in the next cycle. If `stb_n` is low in the same cycle, the strobe wins: `ibf` stays 1 and the latch takes the new bus value.
- R4: A host write to address 0 (`host_wr`=1) loads `host_wdata` into the output latch and drives `obf_n` low from the next cycle.
- R5: `pa_oe` is 1 exactly while `ack_n` is 0, in the same cycle and without a register. `pa_out` shows the output latch while `pa_oe` is 1 and is 0 otherwise.
- R6: `ack_n` low sets `obf_n` back to 1 in the next cycle. A host write to address 0 in the same cycle wins, so `obf_n` stays 0 and the new byte is held.
- R7: A write to address 1 sets the output-side interrupt enable from bit 6, the input-side enable from bit 4, and `gp_out` from bits 2..0. A read of address 1 returns the status byte, with each field at its bit:
  - bit 7: `obf_n`
  - bit 6: output-side enable
  - bit 5: `ibf`
  - bit 4: input-side enable
  - bit 3: `intr`
  - bits 2..0: `gp_in`
- R8: `intr` is the OR of (`ibf` AND input-side enable) and (`obf_n` high, meaning the output latch is empty, AND output-side enable).
- R9: A write to address 2 stores `host_wdata` in a plain register. That register drives `aux_out` and reads back at address 2. Address 3 reads 0.
- R10: While `stb_n` is high, changes on `pa_in` leave the input latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (side effect only at address 0) |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the addressed register |
| pa_in | input | 8 | Peripheral bus value seen at the pins |
| pa_out | output | 8 | Data driven onto the peripheral bus |
| pa_oe | output | 1 | Drive enable for the peripheral bus |
| stb_n | input | 1 | Active-low input strobe |
| ack_n | input | 1 | Active-low acknowledge |
| ibf | output | 1 | Input latch holds unread data |
| obf_n | output | 1 | Active-low: output latch holds unsent data |
| intr | output | 1 | Shared interrupt request |
| gp_in | input | 3 | General-purpose control-port inputs |
| gp_out | output | 3 | General-purpose control-port outputs |
| aux_out | output | 8 | Plain register standing in for the other group |

## Verification
Two pairs of events can land in the same cycle:
- the peripheral strobe and the host read that empties the input latch;
- the acknowledge and the host write that refills the output latch.

The random stimulus lowers `stb_n` and `ack_n` and issues host accesses independently on every cycle, so both collisions occur many times. Directed steps also force each collision on purpose. After each collision, the flag is compared with a bench model in which the peripheral strobe wins the input side and the host write wins the output side. Every following read is checked against that model's latch contents.

// File: rtl/bhp_pkg.sv
`timescale 1ns/1ps
package bhp_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd1;
    localparam logic [ADDR_W-1:0] A_AUX  = 2'd2;
endpackage

// File: rtl/bhp_in_latch.sv
`timescale 1ns/1ps
module bhp_in_latch #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb_n,
    input  logic [DW-1:0] bus_in,
    input  logic          take,
    output logic [DW-1:0] data_o,
    output logic          full_o
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          full;
    } in_st_t;

    in_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) st_d.full = 1'b0;
        if (!stb_n) begin
            st_d.data = bus_in;
            st_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o = st_q.data;
    assign full_o = st_q.full;
endmodule

// File: rtl/bhp_out_latch.sv
`timescale 1ns/1ps
module bhp_out_latch #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ack_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    output logic          full_n_o
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          full_n;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!ack_n) st_d.full_n = 1'b1;
        if (load) begin
            st_d.data   = load_data;
            st_d.full_n = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{data: '0, full_n: 1'b1};
        else        st_q <= st_d;
    end

    assign bus_oe   = ~ack_n;
    assign bus_out  = ack_n ? '0 : st_q.data;
    assign full_n_o = st_q.full_n;
endmodule

// File: rtl/bidir_hs_port.sv
`timescale 1ns/1ps
module bidir_hs_port #(
    parameter int DW           = 8,
    parameter int GPW          = 3,
    parameter int INTE_OUT_BIT = 6,
    parameter int INTE_IN_BIT  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_wr,
    input  logic                       host_rd,
    input  logic [bhp_pkg::ADDR_W-1:0] host_addr,
    input  logic [DW-1:0]              host_wdata,
    output logic [DW-1:0]              host_rdata,
    input  logic [DW-1:0]              pa_in,
    output logic [DW-1:0]              pa_out,
    output logic                       pa_oe,
    input  logic                       stb_n,
    input  logic                       ack_n,
    output logic                       ibf,
    output logic                       obf_n,
    output logic                       intr,
    input  logic [GPW-1:0]             gp_in,
    output logic [GPW-1:0]             gp_out,
    output logic [DW-1:0]              aux_out
);
    import bhp_pkg::*;

    localparam int ST_OBF  = DW - 1;
    localparam int ST_IBF  = DW - 3;
    localparam int ST_INTR = DW - 5;

    typedef struct packed {
        logic           inte_out;
        logic           inte_in;
        logic [GPW-1:0] gp;
        logic [DW-1:0]  aux;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;
    logic [DW-1:0] in_data;
    logic          take, load;

    assign take = host_rd && (host_addr == A_DATA);
    assign load = host_wr && (host_addr == A_DATA);

    bhp_in_latch #(.DW(DW)) u_in (
        .clk(clk), .rst_n(rst_n), .stb_n(stb_n), .bus_in(pa_in),
        .take(take), .data_o(in_data), .full_o(ibf)
    );

    bhp_out_latch #(.DW(DW)) u_out (
        .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .load(load),
        .load_data(host_wdata), .bus_out(pa_out), .bus_oe(pa_oe),
        .full_n_o(obf_n)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (host_wr && host_addr == A_CTRL) begin
            ctl_d.inte_out = host_wdata[INTE_OUT_BIT];
            ctl_d.inte_in  = host_wdata[INTE_IN_BIT];
            ctl_d.gp       = host_wdata[GPW-1:0];
        end
        if (host_wr && host_addr == A_AUX) ctl_d.aux = host_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign intr    = (ibf & ctl_q.inte_in) | (obf_n & ctl_q.inte_out);
    assign gp_out  = ctl_q.gp;
    assign aux_out = ctl_q.aux;

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            A_DATA: host_rdata = in_data;
            A_CTRL: begin
                host_rdata[ST_OBF]       = obf_n;
                host_rdata[INTE_OUT_BIT] = ctl_q.inte_out;
                host_rdata[ST_IBF]       = ibf;
                host_rdata[INTE_IN_BIT]  = ctl_q.inte_in;
                host_rdata[ST_INTR]      = intr;
                host_rdata[GPW-1:0]      = gp_in;
            end
            A_AUX:   host_rdata = ctl_q.aux;
            default: host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/bhp_chk.sv
`timescale 1ns/1ps
module bhp_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stb_n,
    input logic       ack_n,
    input logic       host_wr,
    input logic       host_rd,
    input logic [1:0] host_addr,
    input logic       ibf,
    input logic       obf_n,
    input logic       pa_oe
);
    // R2
    strobe_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_n |=> ibf);
    // R3
    read_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 2'd0 && stb_n) |=> !ibf);
    // R4
    write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 2'd0) |=> !obf_n);
    // R6
    ack_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && !(host_wr && host_addr == 2'd0)) |=> obf_n);
    // R5
    float_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_n |-> !pa_oe);
endmodule

bind bidir_hs_port bhp_chk u_bhp_chk (
    .clk(clk), .rst_n(rst_n), .stb_n(stb_n), .ack_n(ack_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .ibf(ibf), .obf_n(obf_n), .pa_oe(pa_oe)
);

// File: tb/tb_bidir_hs_port.sv
`timescale 1ns/1ps
module tb_bidir_hs_port;
    logic       clk = 0, rst_n = 0;
    logic       host_wr = 0, host_rd = 0;
    logic [1:0] host_addr = 0;
    logic [7:0] host_wdata = 0, host_rdata, pa_in = 0, pa_out, aux_out;
    logic       pa_oe, stb_n = 1, ack_n = 1, ibf, obf_n, intr;
    logic [2:0] gp_in = 0, gp_out;

    int compared = 0, mismatched = 0;
    bit done = 0;

    // bench model
    logic [7:0] m_in, m_out, m_aux;
    logic       m_ibf, m_obf_n, m_ie_out, m_ie_in;
    logic [2:0] m_gp;

    bidir_hs_port dut (.*);

    always #2.5 clk = ~clk;

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic f_intr();
        return (m_ibf & m_ie_in) | (m_obf_n & m_ie_out);
    endfunction

    function automatic logic [7:0] f_rdata(logic [1:0] a);
        case (a)
            2'd0: return m_in;
            2'd1: return {m_obf_n, m_ie_out, m_ibf, m_ie_in, f_intr(), gp_in};
            2'd2: return m_aux;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string f_rtag(logic [1:0] a);
        case (a)
            2'd0: return "R2";
            2'd1: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic model_reset();
        m_in = 0; m_out = 0; m_aux = 0; m_ibf = 0; m_obf_n = 1;
        m_ie_out = 0; m_ie_in = 0; m_gp = 0;
    endtask

    // check outputs for current inputs, clock, advance the model
    task automatic step();
        #1;
        chk(f_rtag(host_addr), host_rdata, f_rdata(host_addr));
        chk("R5 oe", {7'd0, pa_oe}, {7'd0, !ack_n});
        chk("R5 data", pa_out, ack_n ? 8'h00 : m_out);
        chk("R8", {7'd0, intr}, {7'd0, f_intr()});
        chk("R3 ibf", {7'd0, ibf}, {7'd0, m_ibf});
        chk("R6 obf", {7'd0, obf_n}, {7'd0, m_obf_n});
        chk("R7 gp", {5'd0, gp_out}, {5'd0, m_gp});
        chk("R9 aux", aux_out, m_aux);
        @(posedge clk);
        if (host_rd && host_addr == 0) m_ibf = 0;
        if (!stb_n) begin m_in = pa_in; m_ibf = 1; end
        if (!ack_n) m_obf_n = 1;
        if (host_wr && host_addr == 0) begin m_out = host_wdata; m_obf_n = 0; end
        if (host_wr && host_addr == 1) begin
            m_ie_out = host_wdata[6]; m_ie_in = host_wdata[4]; m_gp = host_wdata[2:0];
        end
        if (host_wr && host_addr == 2) m_aux = host_wdata;
        @(negedge clk);
    endtask

    task automatic drive(logic wr, logic rd, logic [1:0] a, logic [7:0] wd,
                         logic [7:0] bus, logic s, logic k);
        host_wr = wr; host_rd = rd; host_addr = a; host_wdata = wd;
        pa_in = bus; stb_n = s; ack_n = k;
        step();
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        #12;
        // R1: reset state
        chk("R1 ibf", {7'd0, ibf}, 8'd0);
        chk("R1 obf_n", {7'd0, obf_n}, 8'd1);
        chk("R1 oe", {7'd0, pa_oe}, 8'd0);
        chk("R1 intr", {7'd0, intr}, 8'd0);
        chk("R1 rdata", host_rdata, 8'd0);
        chk("R1 aux", aux_out, 8'd0);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        // R2 capture, then R10: bus changes with strobe high are ignored
        drive(0, 0, 0, 0, 8'hA5, 0, 1);
        drive(0, 0, 0, 0, 8'h3C, 1, 1);
        drive(0, 0, 0, 0, 8'hFF, 1, 1);
        chk("R10", host_rdata, 8'hA5);
        // R3 collision: read and strobe together, strobe wins
        drive(0, 1, 0, 0, 8'h77, 0, 1);
        drive(0, 1, 0, 0, 8'h00, 1, 1);
        chk("R3 empty", {7'd0, ibf}, 8'd0);
        // R4 then R5 drive then R6 collision: ack and write together
        drive(1, 0, 0, 8'h5A, 0, 1, 1);
        drive(0, 0, 0, 0, 0, 1, 0);
        drive(1, 0, 0, 8'hC3, 0, 1, 0);
        chk("R6 write wins", {7'd0, obf_n}, 8'd0);
        drive(0, 0, 0, 0, 0, 1, 0);
        // R7/R8 enables
        drive(1, 0, 1, 8'h55, 0, 1, 1);
        drive(1, 0, 2, 8'h9E, 0, 0, 1);
        drive(0, 0, 3, 0, 0, 1, 1);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            gp_in = 3'($urandom);
            drive(($urandom % 4) == 0, ($urandom % 3) == 0, 2'($urandom),
                  8'($urandom), 8'($urandom), ($urandom % 4) != 0,
                  ($urandom % 4) != 0);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            compared++; mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule